// File: doc/BRIEF.md
# Configuration Stream Framer with Poll Handshake

This block takes a configuration blob of known length and delivers it to an attached controller over a byte-wide mailbox link. The payload arrives one byte at a time on a valid/ready input. The block wraps it in a fixed, length-carrying header. It then sends the payload in groups of four bytes, and a marker byte goes ahead of each group. No byte leaves the block until the mailbox reports that its transmit register is empty.

A second command runs a "loaded" check on the controller. The block waits a bounded time for the transmit side to drain. It then sends a poll byte and waits a bounded time for one reply byte, which it judges. Both commands end with a one-cycle completion pulse that carries a success or error flag. Only one command runs at a time.

Top module: `cfg_stream_framer`

## Requirements
- R1: `tx_write` is only high while `tx_empty` is high. A byte that is waiting is held unchanged until the mailbox is empty. Two writes never occur in back-to-back cycles.
- R2: Each 32-bit word (the word one and the length) goes out as four bytes, least significant byte first.
- R3: For a non-zero length L, the first ten bytes are 0x21, 0x01, 0x00, 0x00, 0x00, 0x21 and then L as a word (L zero-extended to 32 bits).
- R4: After the header, the payload goes out in input order as groups. Each group is the marker 0x21 followed by four payload bytes.
- R5: When L is not a multiple of four, the last group is padded with 0x00 bytes. A frame therefore holds exactly 10 + 5*ceil(L/4) bytes.
- R6: A start with L = 0 writes no byte at all and finishes with `done` and `ok`.
- R7: Payload is taken only through `in_valid && in_ready`, and exactly L bytes are taken per frame.
- R8: The poll command waits up to TMO_CYC cycles for `tx_empty`, then writes 0x72. If the mailbox never empties, it finishes with `err` and writes nothing.
- R9: Once the poll byte is written, the first `rx_full` is consumed with a one-cycle `rx_read`. A reply of 0x32 gives `ok`, and any other value gives `err`.
- R10: If no reply arrives within TMO_CYC cycles after the poll byte is written, the command finishes with `err`.
- R11: After reset all outputs are idle. `done` is a single-cycle pulse, and with it exactly one of `ok`/`err` is high. `busy` is low while `done` is high.
- R12: A start that arrives while `busy` is high is ignored. When `start_cfg` and `start_poll` arrive together, only the configuration frame runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_cfg | input | 1 | Start a configuration frame |
| cfg_len | input | LEN_W | Payload length in bytes, sampled with `start_cfg` |
| start_poll | input | 1 | Start the poll check |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte taken this cycle |
| tx_empty | input | 1 | Mailbox transmit register is empty |
| tx_write | output | 1 | Write strobe for `tx_byte` |
| tx_byte | output | 8 | Byte to the mailbox |
| rx_full | input | 1 | Mailbox holds a received byte |
| rx_byte | input | 8 | Received byte |
| rx_read | output | 1 | Consume the received byte |
| busy | output | 1 | A command is running |
| done | output | 1 | Command finished (one cycle) |
| ok | output | 1 | Finished successfully, valid with `done` |
| err | output | 1 | Finished with an error, valid with `done` |

## Verification
Bytes leave on the clock edge in which `tx_write` and `tx_empty` are both high. The first byte of a frame can follow a start by three cycles at the earliest. `done` rises one edge after the last write, or one edge after the reply is read. A timeout `done` comes TMO_CYC+1 edges after the poll write, or after the start when the mailbox never drains. Because the mailbox model inserts random busy periods, the bench does not fix the cycle of each byte. Instead it records every write in a sample taken 1 ns before the edge, compares the whole stream once the command has ended, and accepts `done` inside a window of a few cycles around each computed due cycle.

// File: rtl/cfgf_pkg.sv
package cfgf_pkg;
  localparam logic [7:0] MARK_BYTE = 8'h21;
  localparam logic [7:0] POLL_BYTE = 8'h72;
  localparam logic [7:0] ACK_BYTE  = 8'h32;
  localparam int unsigned HDR_BYTES = 10;

  typedef enum logic [2:0] {
    FR_IDLE, FR_HDR, FR_MARK, FR_DATA, FR_FIN
  } fr_state_t;

  typedef enum logic [2:0] {
    PL_IDLE, PL_DRAIN, PL_SEND, PL_SENT, PL_LISTEN
  } pl_state_t;
endpackage

// File: rtl/cfgf_tx_gate.sv
module cfgf_tx_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [7:0] req_byte,
  input  logic       tx_empty,
  output logic       accept,
  output logic       idle,
  output logic       tx_write,
  output logic [7:0] tx_byte
);
  logic       pending_q, pending_d;
  logic [7:0] byte_q;
  logic       byte_en;

  // One-byte holding stage: a byte is taken only when the stage is empty,
  // so a cleared stage always stays clear for at least one cycle.
  always_comb begin
    accept    = req && !pending_q;
    tx_write  = pending_q && tx_empty;
    byte_en   = accept;
    pending_d = pending_q;
    if (tx_write) pending_d = 1'b0;
    if (accept)   pending_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= pending_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= 8'h00;
    else if (byte_en) byte_q <= req_byte;
  end

  assign idle    = !pending_q;
  assign tx_byte = byte_q;

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_write |=> !tx_write);  // R1
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !tx_empty) |=> (pending_q && $stable(byte_q)));  // R1
endmodule

// File: rtl/cfgf_framer.sv
module cfgf_framer
  import cfgf_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             accept,
  input  logic             gate_idle,
  output logic             req,
  output logic [7:0]       req_byte,
  output logic             busy,
  output logic             done,
  output logic             ok
);
  localparam logic [3:0] HDR_LAST = 4'(HDR_BYTES - 1);

  fr_state_t        st_q, st_d;
  logic [3:0]       hidx_q, hidx_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [1:0]       gsel_q, gsel_d;
  logic             done_q, done_d;
  logic [31:0]      len_word;
  logic [7:0]       hdr_byte;

  assign len_word = 32'(len_q);

  // Header: marker, word 1 (LSB first), marker, length word (LSB first).
  always_comb begin
    case (hidx_q)
      4'd0, 4'd5: hdr_byte = MARK_BYTE;
      4'd1:       hdr_byte = 8'h01;
      4'd6:       hdr_byte = len_word[7:0];
      4'd7:       hdr_byte = len_word[15:8];
      4'd8:       hdr_byte = len_word[23:16];
      4'd9:       hdr_byte = len_word[31:24];
      default:    hdr_byte = 8'h00;
    endcase
  end

  always_comb begin
    st_d     = st_q;
    hidx_d   = hidx_q;
    rem_d    = rem_q;
    len_d    = len_q;
    gsel_d   = gsel_q;
    done_d   = 1'b0;
    req      = 1'b0;
    req_byte = 8'h00;
    in_ready = 1'b0;
    case (st_q)
      FR_IDLE: begin
        if (start) begin
          len_d  = len;
          rem_d  = len;
          hidx_d = 4'd0;
          gsel_d = 2'd0;
          st_d   = (len == '0) ? FR_FIN : FR_HDR;
        end
      end
      FR_HDR: begin
        req      = 1'b1;
        req_byte = hdr_byte;
        if (accept) begin
          if (hidx_q == HDR_LAST) st_d = FR_MARK;
          else                    hidx_d = hidx_q + 4'd1;
        end
      end
      FR_MARK: begin
        req      = 1'b1;
        req_byte = MARK_BYTE;
        if (accept) begin
          st_d   = FR_DATA;
          gsel_d = 2'd0;
        end
      end
      FR_DATA: begin
        if (rem_q != '0) begin
          req      = in_valid;
          req_byte = in_data;
          in_ready = accept;
        end else begin
          req      = 1'b1;
          req_byte = 8'h00;
        end
        if (accept) begin
          if (rem_q != '0) rem_d = rem_q - LEN_W'(1);
          gsel_d = gsel_q + 2'd1;
          if (gsel_q == 2'd3)
            st_d = (rem_q <= LEN_W'(1)) ? FR_FIN : FR_MARK;
        end
      end
      FR_FIN: begin
        if (gate_idle) begin
          done_d = 1'b1;
          st_d   = FR_IDLE;
        end
      end
      default: st_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      hidx_q <= 4'd0;
      rem_q  <= '0;
      len_q  <= '0;
      gsel_q <= 2'd0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hidx_q <= hidx_d;
      rem_q  <= rem_d;
      len_q  <= len_d;
      gsel_q <= gsel_d;
      done_q <= done_d;
    end
  end

  assign busy = (st_q != FR_IDLE);
  assign done = done_q;
  assign ok   = done_q;

  AST_FR_ALL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_FIN) |-> (rem_q == '0));  // R7
  AST_FR_HDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_DATA) |-> (hidx_q == HDR_LAST));  // R3
  AST_FR_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);  // R11
endmodule

// File: rtl/cfgf_poll.sv
module cfgf_poll
  import cfgf_pkg::*;
#(
  parameter int unsigned TMO_CYC = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tx_empty,
  input  logic       gate_idle,
  input  logic       accept,
  output logic       req,
  output logic [7:0] req_byte,
  input  logic       rx_full,
  input  logic [7:0] rx_byte,
  output logic       rx_read,
  output logic       busy,
  output logic       done,
  output logic       ok,
  output logic       err
);
  localparam int unsigned CNT_W = $clog2(TMO_CYC + 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_CYC - 1);

  pl_state_t        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             ok_q, ok_d;
  logic             err_q, err_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    ok_d     = 1'b0;
    err_d    = 1'b0;
    req      = 1'b0;
    req_byte = POLL_BYTE;
    rx_read  = 1'b0;
    case (st_q)
      PL_IDLE: begin
        if (start) begin
          st_d  = PL_DRAIN;
          cnt_d = '0;
        end
      end
      PL_DRAIN: begin
        if (tx_empty && gate_idle) begin
          st_d = PL_SEND;
        end else if (cnt_q == TMO_LAST) begin
          done_d = 1'b1;
          err_d  = 1'b1;
          st_d   = PL_IDLE;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PL_SEND: begin
        req = 1'b1;
        if (accept) st_d = PL_SENT;
      end
      PL_SENT: begin
        if (gate_idle) begin
          st_d  = PL_LISTEN;
          cnt_d = '0;
        end
      end
      PL_LISTEN: begin
        if (rx_full) begin
          rx_read = 1'b1;
          done_d  = 1'b1;
          ok_d    = (rx_byte == ACK_BYTE);
          err_d   = (rx_byte != ACK_BYTE);
          st_d    = PL_IDLE;
        end else if (cnt_q == TMO_LAST) begin
          done_d = 1'b1;
          err_d  = 1'b1;
          st_d   = PL_IDLE;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: st_d = PL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PL_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      ok_q   <= ok_d;
      err_q  <= err_d;
    end
  end

  assign busy = (st_q != PL_IDLE);
  assign done = done_q;
  assign ok   = ok_q;
  assign err  = err_q;

  AST_PL_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (ok_q != err_q));  // R11
  AST_PL_READ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_read |=> !rx_read);  // R9
  AST_PL_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TMO_LAST);  // R10
endmodule

// File: rtl/cfg_stream_framer.sv
module cfg_stream_framer #(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned TMO_CYC = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_cfg,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             start_poll,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             tx_empty,
  output logic             tx_write,
  output logic [7:0]       tx_byte,
  input  logic             rx_full,
  input  logic [7:0]       rx_byte,
  output logic             rx_read,
  output logic             busy,
  output logic             done,
  output logic             ok,
  output logic             err
);
  logic       fr_busy, pl_busy;
  logic       fr_req, pl_req, req;
  logic [7:0] fr_byte, pl_byte, req_byte;
  logic       accept, gate_idle;
  logic       fr_accept, pl_accept;
  logic       fr_go, pl_go;
  logic       fr_done, fr_ok;
  logic       pl_done, pl_ok, pl_err;

  // Starts are honoured only when idle; the frame wins a tie.
  assign busy  = fr_busy || pl_busy;
  assign fr_go = start_cfg && !busy;
  assign pl_go = start_poll && !start_cfg && !busy;

  assign req       = fr_busy ? fr_req  : pl_req;
  assign req_byte  = fr_busy ? fr_byte : pl_byte;
  assign fr_accept = accept && fr_busy;
  assign pl_accept = accept && !fr_busy;

  cfgf_tx_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_byte (req_byte),
    .tx_empty (tx_empty),
    .accept   (accept),
    .idle     (gate_idle),
    .tx_write (tx_write),
    .tx_byte  (tx_byte)
  );

  cfgf_framer #(.LEN_W(LEN_W)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (fr_go),
    .len       (cfg_len),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .accept    (fr_accept),
    .gate_idle (gate_idle),
    .req       (fr_req),
    .req_byte  (fr_byte),
    .busy      (fr_busy),
    .done      (fr_done),
    .ok        (fr_ok)
  );

  cfgf_poll #(.TMO_CYC(TMO_CYC)) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (pl_go),
    .tx_empty  (tx_empty),
    .gate_idle (gate_idle),
    .accept    (pl_accept),
    .req       (pl_req),
    .req_byte  (pl_byte),
    .rx_full   (rx_full),
    .rx_byte   (rx_byte),
    .rx_read   (rx_read),
    .busy      (pl_busy),
    .done      (pl_done),
    .ok        (pl_ok),
    .err       (pl_err)
  );

  assign done = fr_done || pl_done;
  assign ok   = fr_ok || pl_ok;
  assign err  = pl_err;

  AST_TOP_ONE_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fr_busy && pl_busy));  // R12
  AST_TOP_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R11
endmodule

// File: tb/cfg_stream_framer_tb.sv
`timescale 1ns/1ps
module cfg_stream_framer_tb;
  localparam int LEN_W = 16;
  localparam int TMO   = 40;
  localparam int CAPN  = 512;

  logic clk = 1'b0;
  logic rst_n;
  logic start_cfg, start_poll;
  logic [LEN_W-1:0] cfg_len;
  logic [7:0] in_data;
  logic in_valid, in_ready;
  logic tx_empty, tx_write;
  logic [7:0] tx_byte;
  logic rx_full;
  logic [7:0] rx_byte;
  logic rx_read, busy, done, ok, err;

  always #2 clk = ~clk;

  cfg_stream_framer #(.LEN_W(LEN_W), .TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_cfg(start_cfg), .cfg_len(cfg_len),
    .start_poll(start_poll), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .tx_empty(tx_empty), .tx_write(tx_write),
    .tx_byte(tx_byte), .rx_full(rx_full), .rx_byte(rx_byte),
    .rx_read(rx_read), .busy(busy), .done(done), .ok(ok), .err(err)
  );

  int checks = 0;
  int failures = 0;
  logic [7:0] src [CAPN];
  logic [7:0] cap [CAPN];
  logic [7:0] exp_b [CAPN];
  int exp_n, src_len, src_idx, ncap, consumed, ndone, cyc, tx_cnt, gap_pct;
  bit wr_last, rd_last, hs_last, tx_stuck, prev_wr;

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Mailbox and payload source: drive just after the falling edge,
  // sample 1 ns before the rising edge.
  always begin
    @(negedge clk);
    if (wr_last) begin
      tx_empty = 1'b0;
      tx_cnt = int'($urandom % 4);
    end else if (!tx_empty && !tx_stuck) begin
      if (tx_cnt == 0) tx_empty = 1'b1;
      else tx_cnt--;
    end
    wr_last = 1'b0;
    if (rd_last) rx_full = 1'b0;
    rd_last = 1'b0;
    if (hs_last) src_idx++;
    hs_last = 1'b0;
    if (src_idx < src_len) begin
      in_valid = (int'($urandom % 100) >= gap_pct);
      in_data  = src[src_idx];
    end else begin
      in_valid = 1'b0;
      in_data  = 8'h00;
    end
    #1;
    cyc++;
    if (tx_write) begin
      if (!tx_empty || prev_wr) begin
        checks++; failures++;
        $display("FAIL R1 write while busy or back-to-back actual=%0d expected=%0d", 1, 0);
      end
      if (ncap < CAPN) cap[ncap] = tx_byte;
      ncap++;
      wr_last = 1'b1;
    end
    prev_wr = tx_write;
    if (in_valid && in_ready) begin hs_last = 1'b1; consumed++; end
    if (rx_read) rd_last = 1'b1;
    if (done) ndone++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Expected frame built from the requirement text (R2..R5).
  task automatic build_exp(input int len);
    logic [31:0] lw;
    lw = 32'(len);
    exp_n = 0;
    if (len == 0) return;
    exp_b[0] = 8'h21; exp_b[1] = 8'h01; exp_b[2] = 8'h00;
    exp_b[3] = 8'h00; exp_b[4] = 8'h00; exp_b[5] = 8'h21;
    for (int k = 0; k < 4; k++) exp_b[6+k] = lw[8*k +: 8];
    exp_n = 10;
    for (int g = 0; g < (len + 3) / 4; g++) begin
      exp_b[exp_n] = 8'h21; exp_n++;
      for (int k = 0; k < 4; k++) begin
        exp_b[exp_n] = (g*4 + k < len) ? src[g*4 + k] : 8'h00;
        exp_n++;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // mode 0 plain, 1 restart pokes while busy, 2 both starts together
  task automatic run_cfg(input int len, input int gap, input int mode);
    int bad_h, bad_p, first_p, waitc;
    bit seen;
    for (int i = 0; i < len; i++) src[i] = 8'($urandom);
    if (mode == 2) for (int i = 0; i < len; i++) src[i] = 8'(i + 1);
    gap_pct = gap; src_idx = 0; src_len = len;
    ncap = 0; consumed = 0; ndone = 0;
    start_cfg = 1'b1; cfg_len = LEN_W'(len);
    if (mode == 2) start_poll = 1'b1;
    tick();
    start_cfg = 1'b0; start_poll = 1'b0;
    seen = 1'b0; waitc = 0;
    for (int w = 0; w < 4000; w++) begin
      if (mode == 1 && w == 3) begin start_cfg = 1'b1; start_poll = 1'b1; cfg_len = 3; end
      if (mode == 1 && w == 4) begin start_cfg = 1'b0; start_poll = 1'b0; end
      tick();
      if (done) begin seen = 1'b1; waitc = w; break; end
    end
    chk(seen && ok && !err, "R11", "frame done with ok", int'(ok), 1);
    repeat (mode == 2 ? TMO + 20 : 3) tick();
    build_exp(len);
    chk(ncap == exp_n, "R5", "frame byte count", ncap, exp_n);
    bad_h = 0; bad_p = 0; first_p = -1;
    for (int i = 0; i < exp_n && i < ncap; i++) begin
      if (cap[i] != exp_b[i]) begin
        if (i < 10) bad_h++;
        else begin bad_p++; if (first_p < 0) first_p = i; end
      end
    end
    if (len > 0) begin
      chk(bad_h == 0, "R3", "header mismatches (R2 word order)", bad_h, 0);
      chk(bad_p == 0, "R4", "payload mismatches, first index", first_p, -1);
    end
    chk(consumed == len, "R7", "payload bytes taken", consumed, len);
    chk(ndone == 1, "R12", "done pulses for one frame", ndone, 1);
    if (len == 0) chk(waitc <= 3, "R6", "zero-length finish latency", waitc, 3);
    src_len = 0;
  endtask

  task automatic run_poll(input int dly, input logic [7:0] reply,
                          input bit stuck, input bit exp_ok);
    int wcyc, dcyc, cnt;
    bit seen, inj;
    ncap = 0; ndone = 0; wcyc = -1; dcyc = -1; inj = 1'b0; cnt = dly;
    if (stuck) begin tx_stuck = 1'b1; tx_empty = 1'b0; end
    start_poll = 1'b1;
    tick();
    start_poll = 1'b0;
    seen = 1'b0;
    for (int w = 1; w < 3*TMO + 50; w++) begin
      tick();
      if (ncap == 1 && wcyc < 0) wcyc = w;
      if (wcyc >= 0 && dly >= 0 && !inj) begin
        if (cnt == 0) begin rx_full = 1'b1; rx_byte = reply; inj = 1'b1; end
        else cnt--;
      end
      if (done) begin seen = 1'b1; dcyc = w; break; end
    end
    chk(seen, "R11", "poll done seen", int'(seen), 1);
    chk(ok == exp_ok && err == !exp_ok, "R9", "poll result ok", int'(ok), int'(exp_ok));
    if (stuck) begin
      chk(ncap == 0, "R8", "bytes written while never empty", ncap, 0);
      chk(dcyc >= TMO && dcyc <= TMO + 3, "R8", "drain timeout latency", dcyc, TMO + 1);
    end else begin
      chk(ncap == 1 && cap[0] == 8'h72, "R8", "poll byte", int'(cap[0]), 'h72);
      if (dly < 0)
        chk(dcyc - wcyc >= TMO && dcyc - wcyc <= TMO + 3, "R10",
            "reply timeout latency", dcyc - wcyc, TMO + 1);
    end
    repeat (3) tick();
    if (dly >= 0) chk(!rx_full, "R9", "reply consumed", int'(rx_full), 0);
    tx_stuck = 1'b0; tx_empty = 1'b1; rx_full = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd24680));
    rst_n = 1'b0; start_cfg = 1'b0; start_poll = 1'b0; cfg_len = '0;
    tx_empty = 1'b1; rx_full = 1'b0; rx_byte = 8'h00;
    in_valid = 1'b0; in_data = 8'h00;
    src_len = 0; src_idx = 0; ncap = 0; consumed = 0; ndone = 0; cyc = 0;
    tx_cnt = 0; gap_pct = 0;
    wr_last = 0; rd_last = 0; hs_last = 0; tx_stuck = 0; prev_wr = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    chk(!tx_write && !busy && !done && !in_ready && !rx_read, "R11",
        "outputs idle after reset", int'(busy), 0);
    // directed corners
    run_cfg(0, 0, 0);   // R6
    run_cfg(1, 0, 0);   // R5 three pad bytes
    run_cfg(4, 0, 0);   // R4 exact group
    run_cfg(5, 30, 0);  // R5
    run_cfg(8, 10, 1);  // R12 starts while busy
    run_cfg(4, 0, 2);   // R12 tie goes to frame
    run_cfg(300, 20, 0); // R2 length above 255 uses second byte
    for (int t = 0; t < 20; t++)
      run_cfg(int'($urandom % 40) + 1, int'($urandom % 60), 0);
    run_poll(3, 8'h32, 1'b0, 1'b1);   // R9 ack
    run_poll(0, 8'h55, 1'b0, 1'b0);   // R9 wrong reply
    run_poll(-1, 8'h00, 1'b0, 1'b0);  // R10
    run_poll(-1, 8'h00, 1'b1, 1'b0);  // R8 drain timeout
    run_poll(TMO - 5, 8'h32, 1'b0, 1'b1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule